// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One down-counting timer channel with a clock, a gate input and a waveform output. Software first writes a mode code and then an initial count, low byte before high byte. The channel then produces one of six output behaviours: an interrupt-on-terminal-count level, a gate-triggered one-shot, a rate generator, a square wave, or a strobe that either a software write or a gate edge can start. Counting is binary only. A loaded count of zero stands for the full range of 2^CW clocks.

The counter decrements once per `clk` edge. The live value of the counting element appears on `count_value`, so a separate read path can sample it. A null-count indication stays high from each mode or high-byte write until the new count has reached the counting element. A chip-level wrapper places several channels side by side, and all address decoding stays outside this block.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `out` is 1, `null_count` is 1 and `count_value` is 0.
- R2: A count is written as a low byte (`wr_lo`) followed by a high byte (`wr_hi`). The 16-bit value appears on `count_value` on the clock edge after the `wr_hi` edge. `null_count` goes to 1 on a `wr_mode` or `wr_hi` edge and returns to 0 on that transfer edge.
- R3: Mode code 0 (terminal-count level). A mode write drives `out` to 0, and so does a high-byte write. `out` stays 0 until the counter steps from 1 to 0, which happens N edges after the transfer. It then stays 1.
- R4: Mode code 1 (one-shot). `out` rests at 1. The first edge that sees `gate` high after it was low reloads the count and drives `out` to 0 for N clocks. A further gate rising edge during the pulse restarts the N-clock pulse.
- R5: Mode code 2 (rate generator, N >= 2). `out` is 0 for one clock in every N. That clock is the edge at which the counter reaches 1. The counter then reloads N and the cycle repeats indefinitely.
- R6: Mode code 3 (square wave, N >= 2). The period is N clocks. `out` is 1 for ceil(N/2) clocks and 0 for floor(N/2) clocks, starting with the high phase at the transfer.
- R7: Mode code 4 (software strobe). The count transfer starts counting. N edges later `out` is 0 for exactly one clock. No further pulse follows until a new count is written.
- R8: Mode code 5 (hardware strobe). A gate rising edge reloads the count. N edges later `out` is 0 for exactly one clock. The gate level does not pause counting.
- R9: In mode codes 0, 2, 3 and 4, an edge that sees `gate` low leaves `count_value` unchanged.
- R10: In mode codes 2 and 3, an edge that sees `gate` low drives `out` to 1. The next gate rising edge reloads the initial count.
- R11: A loaded count of 0 behaves as 65536. In mode 0, `out` stays 0 for 65536 clocks after the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_mode | input | 1 | Write strobe for the mode code |
| mode_sel | input | 3 | Mode code 0..5 |
| wr_lo | input | 1 | Write strobe for the count low byte |
| wr_hi | input | 1 | Write strobe for the count high byte |
| wr_data | input | CW/2 | Count byte being written |
| gate | input | 1 | Gate: enable level or trigger edge, depending on mode |
| out | output | 1 | Waveform output |
| count_value | output | CW | Live counting-element value |
| null_count | output | 1 | High while a written count waits for transfer |

## Verification
The assertions assume that `wr_mode`, `wr_lo` and `wr_hi` are never raised in the same cycle, and that no new count is written while a transfer is still pending. They also assume that modes 2 and 3 are only given counts of two or more. The stimulus applies each write strobe for a single cycle, separates writes by at least one idle cycle, and keeps every rate and square-wave count at 2 or above. `gate` is changed only away from the clock edge and is held low during reset.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    MD_TCINT    = 3'd0,
    MD_ONESHOT  = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } tmr_mode_e;

  // Codes 6 and 7 fold onto the rate and square variants.
  function automatic tmr_mode_e norm_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return tmr_mode_e'({1'b0, code[1:0]});
    return tmr_mode_e'(code);
  endfunction

endpackage

// File: rtl/tmr_load_regs.sv
module tmr_load_regs #(
  parameter int CW = 16,
  localparam int BW = CW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_mode,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wr_data,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          null_flag
);

  logic [BW-1:0] lo_q, hi_q;
  logic          pend_q, null_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      pend_q <= 1'b0;
      null_q <= 1'b1;
    end else begin
      if (wr_lo) lo_q <= wr_data;
      if (wr_mode) begin
        pend_q <= 1'b0;
        null_q <= 1'b1;
      end else if (wr_hi) begin
        hi_q   <= wr_data;
        pend_q <= 1'b1;
        null_q <= 1'b1;
      end else if (pend_q) begin
        pend_q <= 1'b0;
        null_q <= 1'b0;
      end
    end
  end

  assign load      = pend_q;
  assign load_val  = {hi_q, lo_q};
  assign null_flag = null_q;

  // R2
  null_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_mode && !wr_hi) |=> !null_flag);

  // R2
  null_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi || wr_mode) |=> null_flag);

endmodule

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_rise
);

  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_rise = gate & ~gate_q;

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  tmr_mode_e     mode_in,
  input  logic          cnt_wr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          gate,
  input  logic          gate_rise,
  output logic [CW-1:0] ce,
  output logic          out_r
);

  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  // A stored zero stands for the full 2^CW range.
  function automatic logic [CW:0] full_val(input logic [CW-1:0] x);
    return (x == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, x};
  endfunction

  // Square wave: high while the remaining count exceeds half the period.
  function automatic logic sq_high(input logic [CW-1:0] nxt, input logic [CW-1:0] n);
    return full_val(nxt) > (full_val(n) >> 1);
  endfunction

  tmr_mode_e     mode_r;
  logic [CW-1:0] init_r;
  logic          run, armed, have_cnt;
  logic          dec_en, tc;
  logic [CW-1:0] sq_nx;

  always_comb begin
    unique case (mode_r)
      MD_TCINT, MD_SWSTROBE: dec_en = run & gate;
      MD_ONESHOT, MD_HWSTROBE: dec_en = run & ~(gate_rise & have_cnt);
      default: dec_en = run & gate & ~gate_rise;
    endcase
  end

  assign tc    = dec_en & (ce == ONE) & ~load & ~mode_wr;
  assign sq_nx = (ce == ONE) ? init_r : ce - ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r   <= MD_TCINT;
      ce       <= '0;
      init_r   <= '0;
      out_r    <= 1'b1;
      run      <= 1'b0;
      armed    <= 1'b0;
      have_cnt <= 1'b0;
    end else if (mode_wr) begin
      mode_r   <= mode_in;
      out_r    <= (mode_in != MD_TCINT);
      run      <= 1'b0;
      armed    <= 1'b0;
      have_cnt <= 1'b0;
    end else if (load) begin
      init_r   <= load_val;
      have_cnt <= 1'b1;
      unique case (mode_r)
        MD_TCINT: begin
          ce <= load_val; run <= 1'b1; out_r <= 1'b0;
        end
        MD_SWSTROBE: begin
          ce <= load_val; run <= 1'b1; armed <= 1'b1; out_r <= 1'b1;
        end
        MD_RATE, MD_SQUARE: begin
          ce <= load_val; run <= 1'b1; out_r <= 1'b1;
        end
        default: begin
          run <= 1'b0; armed <= 1'b0; out_r <= 1'b1;
        end
      endcase
    end else begin
      unique case (mode_r)
        MD_TCINT: begin
          if (cnt_wr) begin
            out_r <= 1'b0;
            run   <= 1'b0;
          end else if (dec_en) begin
            ce <= ce - ONE;
            if (ce == ONE) out_r <= 1'b1;
          end
        end
        MD_SWSTROBE: begin
          out_r <= 1'b1;
          if (dec_en) begin
            ce <= ce - ONE;
            if (ce == ONE && armed) begin
              out_r <= 1'b0;
              armed <= 1'b0;
            end
          end
        end
        MD_ONESHOT: begin
          if (gate_rise && have_cnt) begin
            ce <= init_r; out_r <= 1'b0; run <= 1'b1;
          end else if (dec_en) begin
            ce <= ce - ONE;
            if (ce == ONE) out_r <= 1'b1;
          end
        end
        MD_HWSTROBE: begin
          out_r <= 1'b1;
          if (gate_rise && have_cnt) begin
            ce <= init_r; run <= 1'b1; armed <= 1'b1;
          end else if (dec_en) begin
            ce <= ce - ONE;
            if (ce == ONE && armed) begin
              out_r <= 1'b0;
              armed <= 1'b0;
            end
          end
        end
        MD_RATE: begin
          if (!gate) out_r <= 1'b1;
          else if (gate_rise && run) begin
            ce <= init_r; out_r <= 1'b1;
          end else if (run) begin
            if (ce == ONE) begin
              ce <= init_r; out_r <= 1'b1;
            end else begin
              ce    <= ce - ONE;
              out_r <= (ce != TWO);
            end
          end
        end
        default: begin
          if (!gate) out_r <= 1'b1;
          else if (gate_rise && run) begin
            ce <= init_r; out_r <= 1'b1;
          end else if (run) begin
            ce    <= sq_nx;
            out_r <= sq_high(sq_nx, init_r);
          end
        end
      endcase
    end
  end

  // R3
  tcint_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == MD_TCINT && !mode_wr && !tc && !out_r) |=> !out_r);

  // R4
  oneshot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == MD_ONESHOT && gate_rise && have_cnt && !mode_wr && !load) |=> !out_r);

  // R5
  rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == MD_RATE && !out_r && !mode_wr) |=> out_r);

  // R7
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_r == MD_SWSTROBE || mode_r == MD_HWSTROBE) && !out_r && !mode_wr) |=> out_r);

  // R9
  suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_r == MD_TCINT || mode_r == MD_SWSTROBE || mode_r == MD_RATE || mode_r == MD_SQUARE)
     && !gate && !mode_wr && !load) |=> $stable(ce));

  // R10
  gate_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_r == MD_RATE || mode_r == MD_SQUARE) && !gate && !mode_wr) |=> out_r);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_mode,
  input  logic [2:0]      mode_sel,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [CW/2-1:0] wr_data,
  input  logic            gate,
  output logic            out,
  output logic [CW-1:0]   count_value,
  output logic            null_count
);

  logic          load;
  logic [CW-1:0] load_val;
  logic          gate_rise;

  tmr_load_regs #(.CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mode   (wr_mode),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wr_data   (wr_data),
    .load      (load),
    .load_val  (load_val),
    .null_flag (null_count)
  );

  tmr_gate_edge u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate      (gate),
    .gate_rise (gate_rise)
  );

  tmr_core #(.CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (wr_mode),
    .mode_in   (norm_mode(mode_sel)),
    .cnt_wr    (wr_hi),
    .load      (load),
    .load_val  (load_val),
    .gate      (gate),
    .gate_rise (gate_rise),
    .ce        (count_value),
    .out_r     (out)
  );

endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_mode = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        gate = 1'b0;
  logic        out;
  logic [15:0] count_value;
  logic        null_count;

  always #5 clk = ~clk;

  tmr_channel #(.CW(16)) dut (
    .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .mode_sel(mode_sel),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .gate(gate),
    .out(out), .count_value(count_value), .null_count(null_count)
  );

  int    checks = 0, fails = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // Behavioural reference, all integers.
  int m_mode = 0, m_ce = 0, m_init = 0, m_out = 1;
  int m_run = 0, m_armed = 0, m_have = 0;
  int m_pend = 0, m_null = 1, m_lo = 0, m_hi = 0, m_gprev = 0;

  function automatic int wrapdec(int v);
    return (v + 65535) % 65536;
  endfunction
  function automatic int full(int v);
    return (v == 0) ? 65536 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ce = 0; m_init = 0; m_out = 1; m_run = 0; m_armed = 0;
      m_have = 0; m_pend = 0; m_null = 1; m_lo = 0; m_hi = 0; m_gprev = 0;
    end else begin
      int rise, g, nx, ldv;
      g = gate ? 1 : 0;
      rise = (g == 1 && m_gprev == 0) ? 1 : 0;
      ldv = m_hi * 256 + m_lo;
      if (wr_mode) begin
        m_mode = mode_sel; m_out = (mode_sel == 0) ? 0 : 1;
        m_run = 0; m_armed = 0; m_have = 0;
      end else if (m_pend == 1) begin
        m_init = ldv; m_have = 1;
        case (m_mode)
          0: begin m_ce = ldv; m_run = 1; m_out = 0; end
          4: begin m_ce = ldv; m_run = 1; m_armed = 1; m_out = 1; end
          2, 3: begin m_ce = ldv; m_run = 1; m_out = 1; end
          default: begin m_run = 0; m_armed = 0; m_out = 1; end
        endcase
      end else begin
        case (m_mode)
          0: if (wr_hi) begin m_out = 0; m_run = 0; end
             else if (m_run == 1 && g == 1) begin
               if (m_ce == 1) m_out = 1;
               m_ce = wrapdec(m_ce);
             end
          4: begin
            m_out = 1;
            if (m_run == 1 && g == 1) begin
              if (m_ce == 1 && m_armed == 1) begin m_out = 0; m_armed = 0; end
              m_ce = wrapdec(m_ce);
            end
          end
          1: if (rise == 1 && m_have == 1) begin m_ce = m_init; m_out = 0; m_run = 1; end
             else if (m_run == 1) begin
               if (m_ce == 1) m_out = 1;
               m_ce = wrapdec(m_ce);
             end
          5: begin
            m_out = 1;
            if (rise == 1 && m_have == 1) begin m_ce = m_init; m_run = 1; m_armed = 1; end
            else if (m_run == 1) begin
              if (m_ce == 1 && m_armed == 1) begin m_out = 0; m_armed = 0; end
              m_ce = wrapdec(m_ce);
            end
          end
          default: begin
            if (g == 0) m_out = 1;
            else if (rise == 1 && m_run == 1) begin m_ce = m_init; m_out = 1; end
            else if (m_run == 1) begin
              nx = (m_ce == 1) ? m_init : wrapdec(m_ce);
              if (m_mode == 2) m_out = (nx == 1) ? 0 : 1;
              else m_out = (full(nx) > full(m_init) / 2) ? 1 : 0;
              m_ce = nx;
            end
          end
        endcase
      end
      if (wr_lo) m_lo = wr_data;
      if (wr_mode) begin m_pend = 0; m_null = 1; end
      else if (wr_hi) begin m_hi = wr_data; m_pend = 1; m_null = 1; end
      else if (m_pend == 1) begin m_pend = 0; m_null = 0; end
      m_gprev = g;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (out !== m_out[0] || count_value !== m_ce[15:0] || null_count !== m_null[0]) begin
        fails++;
        $display("FAIL %s model: out=%0b cnt=%0d null=%0b expected out=%0d cnt=%0d null=%0d",
                 cur_req, out, count_value, null_count, m_out, m_ce, m_null);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_mode(input int m);
    @(negedge clk); mode_sel = m[2:0]; wr_mode = 1'b1;
    @(negedge clk); wr_mode = 1'b0;
  endtask

  task automatic write_count(input int n);
    @(negedge clk); wr_data = n[7:0]; wr_lo = 1'b1;
    @(negedge clk); wr_lo = 1'b0;
    @(negedge clk); wr_data = n[15:8]; wr_hi = 1'b1;
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic count_lows(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (out == 1'b0) lows++;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lows, v1;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 out", out, 1);
    chk("R1 null", null_count, 1);
    chk("R1 count", count_value, 0);
    rst_n = 1'b1;
    gate = 1'b1;

    cur_req = "R2";
    write_mode(2);
    write_count(6);
    chk("R2 null pending", null_count, 1);
    tick();
    chk("R2 count transferred", count_value, 6);
    chk("R2 null cleared", null_count, 0);

    cur_req = "R5";
    write_mode(2);
    write_count(4);
    count_lows(12, lows);
    chk("R5 low clocks in 3 periods", lows, 3);

    cur_req = "R6";
    write_mode(3);
    write_count(5);
    count_lows(10, lows);
    chk("R6 odd count low clocks", lows, 4);
    write_count(6);
    count_lows(12, lows);
    chk("R6 even count low clocks", lows, 6);

    cur_req = "R10";
    @(negedge clk); gate = 1'b0;
    tick();
    chk("R10 gate low forces out high", out, 1);
    tick();
    @(negedge clk); gate = 1'b1;
    tick();
    chk("R10 gate rise reloads", count_value, 6);

    cur_req = "R3";
    write_mode(0);
    chk("R3 out low after mode write", out, 0);
    write_count(5);
    count_lows(8, lows);
    chk("R3 low clocks before terminal", lows, 5);
    chk("R3 out held high", out, 1);

    cur_req = "R9";
    write_mode(0);
    write_count(20);
    repeat (3) tick();
    @(negedge clk); gate = 1'b0;
    tick();
    v1 = count_value;
    repeat (3) tick();
    chk("R9 count frozen", count_value, v1);
    chk("R9 out still low", out, 0);
    @(negedge clk); gate = 1'b1;
    repeat (25) tick();

    cur_req = "R7";
    write_mode(4);
    write_count(3);
    count_lows(8, lows);
    chk("R7 single strobe", lows, 1);

    cur_req = "R4";
    @(negedge clk); gate = 1'b0;
    write_mode(1);
    write_count(3);
    tick();
    chk("R4 idle high", out, 1);
    @(negedge clk); gate = 1'b1;
    count_lows(8, lows);
    chk("R4 pulse length", lows, 3);
    @(negedge clk); gate = 1'b0;
    tick();
    @(negedge clk); gate = 1'b1;
    lows = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (out == 1'b0) lows++;
      if (i == 0) gate = 1'b0;
      if (i == 1) gate = 1'b1;
    end
    chk("R4 retrigger extends pulse", lows, 5);

    cur_req = "R8";
    @(negedge clk); gate = 1'b0;
    write_mode(5);
    write_count(4);
    tick();
    @(negedge clk); gate = 1'b1;
    count_lows(8, lows);
    chk("R8 single strobe after trigger", lows, 1);

    cur_req = "R11";
    write_mode(0);
    write_count(0);
    lows = 0;
    for (int i = 0; i < 70000; i++) begin
      tick();
      if (out == 1'b0) lows++;
      else break;
    end
    chk("R11 zero count low span", lows, 65536);

    finish_run();
  end

endmodule